// File: doc/BRIEF.md
# Paired Chip-Select Address Decoder

This block turns the address phase of a processor bus cycle into one of eight active-low memory selects. The selects are grouped into four pairs (A, B, C, D). Each pair has a single register set: base, region size, wait count, external-timing flag, 16-bit flag and enable. The first select of a pair covers the region that starts at the base. The second covers the region of equal size that follows it at once. The block reports the data width of the select that is active. It ends the cycle with a ready pulse, which comes either from an internal wait counter or from an external acknowledge.

A bus cycle is a valid/ready handshake. The master raises `bus_valid` with `bus_addr`. It holds both steady until it sees `bus_ready` or `bus_err`, and then drops `bus_valid` for at least one clock before it starts the next cycle. The block never stalls the master in any other way: `bus_ready` low is the only back-pressure. The address is captured on the first clock of a cycle, so register writes made during a cycle take effect from the next cycle.

After reset only select A0 decodes, so the system can boot from it. An SDRAM mode hands five select pins to an external SDRAM controller: its write, row and column strobes go out on B1, C0 and C1, and its two chip selects go out on D0 and D1.

Top module: `pcs_decoder`

## Requirements
- R1: After reset, pair A is enabled with base 0, the largest legal size (8 MB with default parameters), 7 wait states, 16-bit width and internal timing. Only select A0 decodes. An access to the A1 region or to any other pair's region asserts no select.
- R2: Pin index is 2×pair+half, with pairs A=0, B=1, C=2, D=3, so `cs_n[0]`=A0, `cs_n[1]`=A1, … `cs_n[7]`=D1. The size code k gives a region of 2^(13+k) bytes. Select 0 covers base..base+size−1 and select 1 covers base+size..base+2·size−1. Only the address bits at and above log2(2·size) are compared, so base bits below that are ignored.
- R3: With internal timing and wait field N (0–7), `bus_ready` rises exactly N clocks after the select first goes low. With N=0 it is high in the same cycle as the select.
- R4: With external timing, `bus_ready` follows `ext_ack` while the select is low. The cycle waits indefinitely and never times out.
- R5: `bus_wide` is high while a select of a 16-bit pair is low, and low for an 8-bit pair.
- R6: When enabled regions overlap, the lowest-lettered pair wins. At most one decoded select is low at any time.
- R7: Selects are registered. A select goes low on the first clock edge at which `bus_valid` is sampled high, and returns high on the first edge at which `bus_valid` is sampled low.
- R8: An access that matches no enabled region asserts no select and no ready. `bus_err` rises 32 clocks after the cycle starts and stays high until `bus_valid` drops.
- R9: With `sdram_mode` high, B1, C0 and C1 stop decoding and carry `sd_we_n`, `sd_ras_n` and `sd_cas_n`. D0 and D1 stop decoding and carry `sd_cs_n[0]` and `sd_cs_n[1]`. Selects A0, A1 and B0 decode as usual.
- R10: A pair with its enable clear decodes nothing. Select A1 starts decoding only after the first register write to pair A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe, one pair per write |
| cfg_pair | input | 2 | Pair to write (0=A … 3=D) |
| cfg_base | input | 24 | Base address |
| cfg_size | input | 4 | Size code k, region = 2^(13+k) bytes, clamped to the largest legal code |
| cfg_wait | input | 3 | Internal wait states |
| cfg_ext | input | 1 | 1 = external timing |
| cfg_wide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| cfg_enable | input | 1 | Pair enable |
| sdram_mode | input | 1 | Hand five select pins to the SDRAM controller |
| bus_valid | input | 1 | Address strobe (valid) |
| bus_addr | input | 24 | Byte address |
| ext_ack | input | 1 | External acknowledge for external-timing pairs |
| sd_we_n | input | 1 | SDRAM write strobe routed to B1 |
| sd_ras_n | input | 1 | SDRAM row strobe routed to C0 |
| sd_cas_n | input | 1 | SDRAM column strobe routed to C1 |
| sd_cs_n | input | 2 | SDRAM selects routed to D0 (bit 0) and D1 (bit 1) |
| cs_n | output | 8 | Active-low select pins |
| bus_ready | output | 1 | Cycle complete (ready) |
| bus_wide | output | 1 | Active select is 16-bit |
| bus_err | output | 1 | No region hit, timeout expired |

## Verification
The bench builds the block with its defaults: a 24-bit address, a smallest region of 8 KB, and a 32-clock miss timeout. With 8 KB regions, both edges of each half fit in a few short accesses. With a 32-clock timeout, the error edge can be sampled on its exact clock, and an external-timing cycle can be held well past that count to show that it never times out. A 24-bit space makes the reset region of pair A 8 MB, so the A1 region right above it can be probed directly.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int NUM_PAIRS = 4;
  localparam int NUM_SEL   = 2 * NUM_PAIRS;
  localparam int PAIR_W    = $clog2(NUM_PAIRS);
  localparam int IDX_W     = $clog2(NUM_SEL);
  localparam int CODE_W    = 4;
  localparam int WS_W      = 3;

  // pin positions that the SDRAM mode takes over
  localparam int PIN_B1 = 3;
  localparam int PIN_C0 = 4;
  localparam int PIN_C1 = 5;
  localparam int PIN_D0 = 6;
  localparam int PIN_D1 = 7;

  typedef struct packed {
    logic              en;
    logic              ext;
    logic              wide;
    logic [WS_W-1:0]   ws;
    logic [CODE_W-1:0] code;
  } pair_attr_t;
endpackage

// File: rtl/pcs_cfg_regs.sv
module pcs_cfg_regs
  import pcs_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int MIN_LOG = 13
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr,
  input  logic [PAIR_W-1:0]                    wr_pair,
  input  logic [ADDR_W-1:0]                    wr_base,
  input  logic [CODE_W-1:0]                    wr_code,
  input  logic [WS_W-1:0]                      wr_ws,
  input  logic                                 wr_ext,
  input  logic                                 wr_wide,
  input  logic                                 wr_en,
  output logic [NUM_PAIRS-1:0][ADDR_W-1:0]     base,
  output pair_attr_t [NUM_PAIRS-1:0]           attr,
  output logic                                 a1_live
);
  localparam int MAX_CODE_I = ADDR_W - 1 - MIN_LOG;
  localparam int CODE_LIM   = (MAX_CODE_I > (2**CODE_W - 1)) ? (2**CODE_W - 1) : MAX_CODE_I;
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(CODE_LIM);

  logic [CODE_W-1:0] code_sat;
  assign code_sat = (wr_code > MAX_CODE) ? MAX_CODE : wr_code;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam bit BOOT = (p == 0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base[p]      <= '0;
        attr[p].en   <= BOOT;
        attr[p].ext  <= 1'b0;
        attr[p].wide <= BOOT;
        attr[p].ws   <= BOOT ? '1 : '0;
        attr[p].code <= BOOT ? MAX_CODE : '0;
      end else if (wr && (wr_pair == PAIR_W'(p))) begin
        base[p]      <= wr_base;
        attr[p].en   <= wr_en;
        attr[p].ext  <= wr_ext;
        attr[p].wide <= wr_wide;
        attr[p].ws   <= wr_ws;
        attr[p].code <= code_sat;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             a1_live <= 1'b0;
    else if (wr && (wr_pair == '0))         a1_live <= 1'b1;
  end
endmodule

// File: rtl/pcs_pair_match.sv
module pcs_pair_match
  import pcs_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int MIN_LOG = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [CODE_W-1:0] code,
  output logic              hit,
  output logic              upper
);
  logic [ADDR_W-1:0] mask;
  int                half_bit;

  always_comb begin
    half_bit = MIN_LOG + int'(code);
    mask     = '1;
    upper    = 1'b0;
    for (int b = 0; b < ADDR_W; b++) begin
      if (b <= half_bit) mask[b] = 1'b0;
      if (b == half_bit) upper = addr[b];
    end
    hit = (((addr ^ base) & mask) == '0);
  end
endmodule

// File: rtl/pcs_cycle_ctrl.sv
module pcs_cycle_ctrl
  import pcs_pkg::*;
#(
  parameter int TIMEOUT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             ext_ack,
  input  logic             cand_hit,
  input  logic [IDX_W-1:0] cand_idx,
  input  pair_attr_t       cand_attr,
  output logic             act,
  output logic             hit_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             ready,
  output logic             berr,
  output logic             wide
);
  localparam int TO_W = $clog2(TIMEOUT + 1);
  localparam logic [TO_W-1:0] TO_END = TO_W'(TIMEOUT);

  logic            ext_q, wide_q;
  logic [WS_W-1:0] ws_q, wcnt;
  logic [TO_W-1:0] tcnt;
  logic            start;

  assign start = bus_valid && !act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      hit_q  <= 1'b0;
      idx_q  <= '0;
      ext_q  <= 1'b0;
      wide_q <= 1'b0;
      ws_q   <= '0;
      wcnt   <= '0;
      tcnt   <= '0;
    end else begin
      act <= bus_valid;
      if (start) begin
        hit_q  <= cand_hit;
        idx_q  <= cand_idx;
        ext_q  <= cand_attr.ext;
        wide_q <= cand_attr.wide;
        ws_q   <= cand_attr.ws;
        wcnt   <= '0;
        tcnt   <= '0;
      end else if (act && bus_valid) begin
        if (hit_q && (wcnt != ws_q))    wcnt <= wcnt + 1'b1;
        if (!hit_q && (tcnt != TO_END)) tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign ready = act && hit_q && (ext_q ? ext_ack : (wcnt == ws_q));
  assign berr  = act && !hit_q && (tcnt == TO_END);
  assign wide  = act && hit_q && wide_q;
endmodule

// File: rtl/pcs_pin_mux.sv
module pcs_pin_mux
  import pcs_pkg::*;
(
  input  logic               act,
  input  logic               hit_q,
  input  logic [IDX_W-1:0]   idx_q,
  input  logic               sdram_mode,
  input  logic               sd_we_n,
  input  logic               sd_ras_n,
  input  logic               sd_cas_n,
  input  logic [1:0]         sd_cs_n,
  output logic [NUM_SEL-1:0] cs_n
);
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_pin
    logic dec_n;
    assign dec_n = !(act && hit_q && (idx_q == IDX_W'(i)));
    if (i == PIN_B1) begin : g_we
      assign cs_n[i] = sdram_mode ? sd_we_n : dec_n;
    end else if (i == PIN_C0) begin : g_ras
      assign cs_n[i] = sdram_mode ? sd_ras_n : dec_n;
    end else if (i == PIN_C1) begin : g_cas
      assign cs_n[i] = sdram_mode ? sd_cas_n : dec_n;
    end else if (i == PIN_D0) begin : g_sd0
      assign cs_n[i] = sdram_mode ? sd_cs_n[0] : dec_n;
    end else if (i == PIN_D1) begin : g_sd1
      assign cs_n[i] = sdram_mode ? sd_cs_n[1] : dec_n;
    end else begin : g_plain
      assign cs_n[i] = dec_n;
    end
  end
endmodule

// File: rtl/pcs_decoder.sv
module pcs_decoder
  import pcs_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int MIN_LOG = 13,
  parameter int TIMEOUT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [PAIR_W-1:0]  cfg_pair,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [CODE_W-1:0]  cfg_size,
  input  logic [WS_W-1:0]    cfg_wait,
  input  logic               cfg_ext,
  input  logic               cfg_wide,
  input  logic               cfg_enable,
  input  logic               sdram_mode,
  input  logic               bus_valid,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               ext_ack,
  input  logic               sd_we_n,
  input  logic               sd_ras_n,
  input  logic               sd_cas_n,
  input  logic [1:0]         sd_cs_n,
  output logic [NUM_SEL-1:0] cs_n,
  output logic               bus_ready,
  output logic               bus_wide,
  output logic               bus_err
);
  logic [NUM_PAIRS-1:0][ADDR_W-1:0] base;
  pair_attr_t [NUM_PAIRS-1:0]       attr;
  logic                             a1_live;
  logic [NUM_PAIRS-1:0]             hit, upper;
  logic [NUM_SEL-1:0]               sel_ok;
  logic                             cand_hit;
  logic [IDX_W-1:0]                 cand_idx;
  pair_attr_t                       cand_attr;
  logic                             act, hit_q;
  logic [IDX_W-1:0]                 idx_q;

  pcs_cfg_regs #(.ADDR_W(ADDR_W), .MIN_LOG(MIN_LOG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_pair(cfg_pair),
    .wr_base(cfg_base), .wr_code(cfg_size), .wr_ws(cfg_wait),
    .wr_ext(cfg_ext), .wr_wide(cfg_wide), .wr_en(cfg_enable),
    .base(base), .attr(attr), .a1_live(a1_live)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_match
    pcs_pair_match #(.ADDR_W(ADDR_W), .MIN_LOG(MIN_LOG)) u_match (
      .addr(bus_addr), .base(base[p]), .code(attr[p].code),
      .hit(hit[p]), .upper(upper[p])
    );
  end

  // which selects may decode under the current mode
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_ok
    localparam bool_sd = (i == PIN_B1) || (i == PIN_C0) || (i == PIN_C1) ||
                         (i == PIN_D0) || (i == PIN_D1);
    if (i == 1) begin : g_a1
      assign sel_ok[i] = attr[i/2].en && a1_live;
    end else if (bool_sd) begin : g_sd
      assign sel_ok[i] = attr[i/2].en && !sdram_mode;
    end else begin : g_gp
      assign sel_ok[i] = attr[i/2].en;
    end
  end

  // lowest-lettered matching pair wins
  always_comb begin
    cand_hit  = 1'b0;
    cand_idx  = '0;
    cand_attr = '0;
    for (int p = NUM_PAIRS - 1; p >= 0; p--) begin
      if (hit[p] && sel_ok[2*p + int'(upper[p])]) begin
        cand_hit  = 1'b1;
        cand_idx  = IDX_W'(2*p + int'(upper[p]));
        cand_attr = attr[p];
      end
    end
  end

  pcs_cycle_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .ext_ack(ext_ack),
    .cand_hit(cand_hit), .cand_idx(cand_idx), .cand_attr(cand_attr),
    .act(act), .hit_q(hit_q), .idx_q(idx_q),
    .ready(bus_ready), .berr(bus_err), .wide(bus_wide)
  );

  pcs_pin_mux u_pins (
    .act(act), .hit_q(hit_q), .idx_q(idx_q), .sdram_mode(sdram_mode),
    .sd_we_n(sd_we_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_cs_n(sd_cs_n), .cs_n(cs_n)
  );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int NSEL = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sdram_mode,
  input logic            bus_valid,
  input logic [NSEL-1:0] cs_n,
  input logic            bus_ready,
  input logic            bus_wide,
  input logic            bus_err
);
  // R6
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdram_mode |-> ($countones(~cs_n) <= 1));

  // R7
  strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && !sdram_mode) |=> (sdram_mode || (&cs_n)));

  // R8
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (!bus_ready && (&cs_n[2:0])));

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && bus_valid) |=> bus_err);

  // R3
  ready_with_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && !sdram_mode) |-> !(&cs_n));

  // R5
  wide_with_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wide && !sdram_mode) |-> !(&cs_n));
endmodule

bind pcs_decoder pcs_checker #(.NSEL(pcs_pkg::NUM_SEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdram_mode(sdram_mode), .bus_valid(bus_valid),
  .cs_n(cs_n), .bus_ready(bus_ready), .bus_wide(bus_wide), .bus_err(bus_err)
);

// File: tb/sim_pcs_decoder.sv
`timescale 1ns/1ps
module sim_pcs_decoder;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_ext = 0, cfg_wide = 0, cfg_enable = 0;
  logic [1:0] cfg_pair = 0;
  logic [AW-1:0] cfg_base = 0;
  logic [3:0] cfg_size = 0;
  logic [2:0] cfg_wait = 0;
  logic sdram_mode = 0, bus_valid = 0, ext_ack = 0;
  logic [AW-1:0] bus_addr = 0;
  logic sd_we_n = 1, sd_ras_n = 1, sd_cas_n = 1;
  logic [1:0] sd_cs_n = 2'b11;
  logic [7:0] cs_n;
  logic bus_ready, bus_wide, bus_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pcs_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pair(cfg_pair),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_wait(cfg_wait),
    .cfg_ext(cfg_ext), .cfg_wide(cfg_wide), .cfg_enable(cfg_enable),
    .sdram_mode(sdram_mode), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .ext_ack(ext_ack), .sd_we_n(sd_we_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_cs_n(sd_cs_n), .cs_n(cs_n),
    .bus_ready(bus_ready), .bus_wide(bus_wide), .bus_err(bus_err)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] sel(int idx);
    return ~(8'h01 << idx);
  endfunction

  task automatic cfg(int pair, logic [AW-1:0] b, int code, int ws,
                     bit ext, bit wide, bit en);
    @(negedge clk);
    cfg_wr = 1; cfg_pair = 2'(pair); cfg_base = b; cfg_size = 4'(code);
    cfg_wait = 3'(ws); cfg_ext = ext; cfg_wide = wide; cfg_enable = en;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  // leaves the bench at the first sample after the capturing edge
  task automatic begin_cycle(logic [AW-1:0] a);
    @(negedge clk);
    bus_addr = a; bus_valid = 1;
    @(negedge clk);
  endtask

  task automatic end_cycle();
    bus_valid = 0;
    @(negedge clk);
  endtask

  task automatic ready_after(string req, int n);
    for (int k = 0; k <= n; k++) begin
      check(req, 32'(bus_ready), 32'(k == n));
      if (k < n) @(negedge clk);
    end
  endtask

  task automatic access(string req, logic [AW-1:0] a, logic [7:0] exp);
    begin_cycle(a);
    check(req, 32'(cs_n), 32'(exp));
    end_cycle();
  endtask

  task automatic t_reset();
    check("R1 idle pins", 32'(cs_n), 32'hFF);
    check("R1 idle ready", 32'(bus_ready), 0);
    check("R8 idle err", 32'(bus_err), 0);
    @(negedge clk);
    bus_addr = 24'h000010; bus_valid = 1;
    #1 check("R7 not yet registered", 32'(cs_n), 32'hFF);
    @(negedge clk);
    check("R1 A0 boot select", 32'(cs_n), 32'(sel(0)));
    check("R5 A0 wide", 32'(bus_wide), 1);
    ready_after("R3 reset 7 waits", 7);
    end_cycle();
    check("R7 released", 32'(cs_n), 32'hFF);
    begin_cycle(24'h800000);
    check("R1 A1 dead", 32'(cs_n), 32'hFF);
    repeat (31) @(negedge clk);
    check("R8 err before 32", 32'(bus_err), 0);
    @(negedge clk);
    check("R8 err at 32", 32'(bus_err), 1);
    check("R8 no ready", 32'(bus_ready), 0);
    end_cycle();
    check("R8 err clears", 32'(bus_err), 0);
  endtask

  task automatic t_pairs();
    cfg(0, 24'h000000, 0, 0, 0, 1, 1);
    begin_cycle(24'h002000);
    check("R10 A1 live after write", 32'(cs_n), 32'(sel(1)));
    ready_after("R3 zero waits", 0);
    end_cycle();
    access("R2 A0 top", 24'h001FFF, sel(0));
    access("R2 above A1", 24'h004000, 8'hFF);
    cfg(1, 24'h100000, 3, 2, 0, 0, 1);
    access("R2 B0 top", 24'h10FFFF, sel(2));
    begin_cycle(24'h110000);
    check("R2 B1 bottom", 32'(cs_n), 32'(sel(3)));
    check("R5 8-bit pair", 32'(bus_wide), 0);
    ready_after("R3 two waits", 2);
    end_cycle();
    access("R2 past B1", 24'h120000, 8'hFF);
    access("R2 below B0", 24'h0FFFFF, 8'hFF);
  endtask

  task automatic t_align();
    cfg(2, 24'h400123, 0, 0, 0, 1, 1);
    access("R2 low base bits ignored", 24'h400000, sel(4));
    access("R2 C1 top", 24'h403FFF, sel(5));
    access("R2 past C1", 24'h404000, 8'hFF);
  endtask

  task automatic t_ext();
    cfg(3, 24'h800000, 1, 0, 1, 1, 1);
    begin_cycle(24'h800000);
    check("R4 D0 select", 32'(cs_n), 32'(sel(6)));
    repeat (40) @(negedge clk);
    check("R4 waits without ack", 32'(bus_ready), 0);
    check("R4 no timeout", 32'(bus_err), 0);
    check("R4 select held", 32'(cs_n), 32'(sel(6)));
    ext_ack = 1;
    #1 check("R4 ready follows ack", 32'(bus_ready), 1);
    @(negedge clk);
    ext_ack = 0;
    end_cycle();
    access("R4 D1 region", 24'h804000, sel(7));
  endtask

  task automatic t_prio();
    cfg(2, 24'h100000, 3, 0, 0, 1, 1);
    access("R6 B beats C low", 24'h100000, sel(2));
    access("R6 B beats C high", 24'h110000, sel(3));
    cfg(2, 24'h000000, 0, 0, 0, 1, 1);
    access("R6 A beats C", 24'h000000, sel(0));
  endtask

  task automatic t_disable();
    cfg(1, 24'h100000, 3, 2, 0, 0, 0);
    access("R10 disabled pair", 24'h100000, 8'hFF);
    cfg(1, 24'h100000, 3, 2, 0, 0, 1);
  endtask

  task automatic t_sdram();
    @(negedge clk);
    sdram_mode = 1; sd_we_n = 0; sd_ras_n = 1; sd_cas_n = 0; sd_cs_n = 2'b01;
    #1 check("R9 strobes on pins", 32'(cs_n[7:3]), 32'(5'b01010));
    check("R9 decoded pins idle", 32'(cs_n[2:0]), 32'h7);
    begin_cycle(24'h100000);
    check("R9 B0 still decodes", 32'(cs_n[2:0]), 32'(3'b011));
    end_cycle();
    begin_cycle(24'h110000);
    check("R9 B1 no decode", 32'(cs_n[2:0]), 32'h7);
    check("R9 B1 no ready", 32'(bus_ready), 0);
    end_cycle();
    begin_cycle(24'h800000);
    check("R9 D no decode", 32'(cs_n[2:0]), 32'h7);
    sd_we_n = 1; sd_ras_n = 0; sd_cas_n = 1; sd_cs_n = 2'b10;
    #1 check("R9 strobes follow", 32'(cs_n[7:3]), 32'(5'b10101));
    end_cycle();
    sdram_mode = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pairs();
    t_align();
    t_ext();
    t_prio();
    t_disable();
    t_sdram();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got hung run expected completion");
    summary();
  end
endmodule